// File: doc/BRIEF.md
# NAND Command Front End

This block is the device-side command interpreter for a small-page NAND memory. The memory has a multiplexed 8-bit bus. The block samples the bus when the write strobe rises while the chip is selected. The two latch-enable inputs decide what each byte is: a command byte goes to the command decoder, an address byte goes to the column and row registers, and a plain byte goes to the program data path as a one-cycle write pulse. The block tracks the current operation mode and the column pointer area (lower half, upper half or spare bytes). Status and identification bytes are driven onto the output bus while the read strobe is low.

Array activity is not modelled. In its place, a per-operation cycle-count parameter sets how long the ready/busy output stays low after a read, program, erase or reset starts. While that output is low, only the reset and status-read commands get through. Write protect blocks program and erase and leaves a failure flag in the status byte. All inputs are synchronous to `clk`, and `rst` is an active-high synchronous reset that stands in for power-up.

Top module: `nand_cmd_frontend`

## Requirements
- R1: A byte is taken only when `we_n` rises while `ce_n` is low. With `cle` high it is a command, with `ale` high it is an address, and with both low it is data. Strobes with `ce_n` high are ignored.
- R2: After `rst` the block is ready (`rb`=1), `col_addr` and `row_addr` are 0, `wr_valid` and `io_oe` are 0, the mode is read, the pointer is the lower area, and a status read returns C0h while `wp_n` is high.
- R3: Command 00h selects the lower area and sets column = address byte. Command 01h selects the upper area and sets column = 256 + byte. Command 50h selects the spare area and sets column = 512 + byte[3:0], ignoring byte[7:4]. The second and third address bytes form `row_addr` (low byte first). The third read address byte drives `rb` low for exactly READ_CYC cycles.
- R4: The 00h and 50h pointers persist across operations, and a new group of three address bytes in read mode starts another read without a new command. The 01h pointer applies to one operation only and then reverts to the lower area.
- R5: Address bytes beyond the count an operation needs are ignored: three for read and program, two for erase. For erase, `row_addr` = {second byte, first byte}.
- R6: After 80h and three address bytes, each data byte produces a one-cycle `wr_valid` pulse with that byte on `wr_data`. Command 10h then drives `rb` low for exactly PROG_CYC cycles.
- R7: Command 10h with no 80h setup before it, and command D0h with no 60h setup before it, are ignored and start nothing.
- R8: Command 60h, two address bytes, then D0h drives `rb` low for exactly ERASE_CYC cycles.
- R9: While `rb` is low, only FFh and 70h are accepted. All other commands, and all address and data bytes, leave mode, pointer and address unchanged.
- R10: The status byte has bit 0 = fail (1 = failed), bit 6 = ready (1 = ready), bit 7 = `wp_n`, and bits 1 to 5 = 0. It can be read while busy, and status mode holds until another command is accepted.
- R11: With `wp_n` low, a program or erase confirm starts no busy period and sets the fail bit. The next confirm that does start clears the fail bit.
- R12: Command FFh drives `rb` low for RESET_CYC cycles and clears column, row, pointer (to the lower area), fail bit and mode. It aborts a busy program. A second FFh during a reset busy period is ignored and does not restart the count.
- R13: After 90h and one address byte, successive read strobes return MAKER_ID, then DEVICE_ID, then 00h for every later strobe. This holds until another command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Marks the bus byte as a command |
| ale | input | 1 | Marks the bus byte as an address |
| we_n | input | 1 | Write strobe; byte taken on its rising edge |
| re_n | input | 1 | Read strobe, active low |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Bus byte in |
| io_out | output | 8 | Status or identification byte out |
| io_oe | output | 1 | Output enable for `io_out` |
| rb | output | 1 | Ready (1) / busy (0) |
| col_addr | output | 10 | Latched column including pointer area |
| row_addr | output | 16 | Latched row (page) address |
| wr_valid | output | 1 | One-cycle pulse per program data byte |
| wr_data | output | 8 | Program data byte |

## Verification
A wrong mode or pointer register shows up on the very next address group: `col_addr` gets the wrong area offset, or the address is not taken at all. A busy counter that is off by even one cycle changes the number of cycles `rb` stays low, so the bench counts that length exactly for every operation. A filter that lets a command through while busy, or a reset that restarts itself, becomes visible at the next status read or in the length of the busy period. These failures appear within a few strobes of the stimulus.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

    localparam int BUS_W     = 8;
    localparam int ROW_BYTES = 2;
    localparam int ROW_W     = ROW_BYTES * BUS_W;
    localparam int COL_W     = 10;
    localparam int HALF_SPAN = 256;
    localparam int MAIN_SPAN = 512;
    localparam int SPARE_W   = 4;

    localparam logic [BUS_W-1:0] OPC_PTR_LOW   = 8'h00;
    localparam logic [BUS_W-1:0] OPC_PTR_HIGH  = 8'h01;
    localparam logic [BUS_W-1:0] OPC_PTR_SPARE = 8'h50;
    localparam logic [BUS_W-1:0] OPC_IDENT     = 8'h90;
    localparam logic [BUS_W-1:0] OPC_RESET     = 8'hFF;
    localparam logic [BUS_W-1:0] OPC_LOAD      = 8'h80;
    localparam logic [BUS_W-1:0] OPC_LOAD_GO   = 8'h10;
    localparam logic [BUS_W-1:0] OPC_WIPE      = 8'h60;
    localparam logic [BUS_W-1:0] OPC_WIPE_GO   = 8'hD0;
    localparam logic [BUS_W-1:0] OPC_STATUS    = 8'h70;

    typedef enum logic [1:0] {
        BK_CMD,
        BK_ADDR,
        BK_DATA
    } byte_kind_e;

    typedef struct packed {
        logic             vld;
        byte_kind_e       kind;
        logic [BUS_W-1:0] val;
    } bus_evt_t;

    typedef enum logic [2:0] {
        MD_READ,
        MD_IDENT,
        MD_STATUS,
        MD_LOAD,
        MD_WIPE
    } mode_e;

    typedef enum logic [1:0] {
        AR_LOW,
        AR_HIGH,
        AR_SPARE
    } area_e;

    typedef enum logic [1:0] {
        OP_READ,
        OP_LOAD,
        OP_WIPE,
        OP_RESET
    } op_e;

    function automatic logic [COL_W-1:0] col_of(area_e a, logic [BUS_W-1:0] b);
        logic [COL_W-1:0] c;
        case (a)
            AR_HIGH:  c = COL_W'(HALF_SPAN) + COL_W'(b);
            AR_SPARE: c = COL_W'(MAIN_SPAN) + COL_W'(b[SPARE_W-1:0]);
            default:  c = COL_W'(b);
        endcase
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] status_of(logic wp_n, logic busy, logic fail);
        return {wp_n, ~busy, 5'b00000, fail};
    endfunction

    function automatic logic [1:0] addr_need(mode_e m);
        return (m == MD_WIPE) ? 2'(ROW_BYTES) : 2'(ROW_BYTES + 1);
    endfunction

endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler
    import nand_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_n,
    input  logic             cle,
    input  logic             ale,
    input  logic             we_n,
    input  logic             re_n,
    input  logic [BUS_W-1:0] io_in,
    output bus_evt_t         evt,
    output logic             re_rise
);

    logic we_q;
    logic re_q;
    logic we_edge;

    assign we_edge = we_n & ~we_q & ~ce_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q    <= 1'b1;
            re_q    <= 1'b1;
            evt     <= '0;
            re_rise <= 1'b0;
        end else begin
            we_q     <= we_n;
            re_q     <= re_n;
            evt.vld  <= we_edge & ~(cle & ale);
            evt.kind <= cle ? BK_CMD : (ale ? BK_ADDR : BK_DATA);
            evt.val  <= io_in;
            re_rise  <= re_n & ~re_q & ~ce_n;
        end
    end

    assert_one_kind_R1: assert property (@(posedge clk) disable iff (rst)
        (we_edge && cle && ale) |=> !evt.vld);

endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    assert_load_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> busy);

    assert_idle_stays_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> !busy);

endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder
    import nand_fe_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int READ_CYC  = 500,
    parameter int LOAD_CYC  = 4000,
    parameter int WIPE_CYC  = 40000,
    parameter int RESET_CYC = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    input  logic             re_rise,
    input  logic             wp_n,
    input  logic             busy,
    output logic             tload,
    output logic [CNT_W-1:0] tval,
    output mode_e            mode_o,
    output logic [COL_W-1:0] col_o,
    output logic [ROW_W-1:0] row_o,
    output logic             fail_o,
    output logic [1:0]       id_idx_o,
    output logic             wr_vld_o,
    output logic [BUS_W-1:0] wr_byte_o
);

    mode_e            mode_q, mode_d;
    area_e            area_q, area_d;
    op_e              op_q, op_d;
    logic [1:0]       acnt_q, acnt_d;
    logic [COL_W-1:0] col_q, col_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic             fail_q, fail_d;
    logic [1:0]       idx_q, idx_d;
    logic             wrv_q, wrv_d;
    logic [BUS_W-1:0] wrb_q, wrb_d;

    logic cmd_ok;
    logic free_addr;
    logic free_data;
    logic reset_locked;

    assign cmd_ok       = evt.vld && (evt.kind == BK_CMD) &&
                          (!busy || evt.val == OPC_RESET || evt.val == OPC_STATUS);
    assign free_addr    = evt.vld && (evt.kind == BK_ADDR) && !busy;
    assign free_data    = evt.vld && (evt.kind == BK_DATA) && !busy;
    assign reset_locked = busy && (op_q == OP_RESET);

    always_comb begin
        logic launched;
        int   bi;
        mode_d   = mode_q;
        area_d   = area_q;
        op_d     = op_q;
        acnt_d   = acnt_q;
        col_d    = col_q;
        row_d    = row_q;
        fail_d   = fail_q;
        idx_d    = idx_q;
        wrv_d    = 1'b0;
        wrb_d    = wrb_q;
        tload    = 1'b0;
        tval     = '0;
        launched = 1'b0;
        bi       = 0;

        if (cmd_ok) begin
            case (evt.val)
                OPC_RESET: begin
                    if (!reset_locked) begin
                        tload  = 1'b1;
                        tval   = CNT_W'(RESET_CYC);
                        op_d   = OP_RESET;
                        col_d  = '0;
                        row_d  = '0;
                        area_d = AR_LOW;
                        fail_d = 1'b0;
                        mode_d = MD_READ;
                        acnt_d = '0;
                    end
                end
                OPC_STATUS: mode_d = MD_STATUS;
                OPC_PTR_LOW: begin
                    mode_d = MD_READ;
                    area_d = AR_LOW;
                    acnt_d = '0;
                end
                OPC_PTR_HIGH: begin
                    mode_d = MD_READ;
                    area_d = AR_HIGH;
                    acnt_d = '0;
                end
                OPC_PTR_SPARE: begin
                    mode_d = MD_READ;
                    area_d = AR_SPARE;
                    acnt_d = '0;
                end
                OPC_IDENT: begin
                    mode_d = MD_IDENT;
                    acnt_d = '0;
                    idx_d  = '0;
                end
                OPC_LOAD: begin
                    mode_d = MD_LOAD;
                    acnt_d = '0;
                end
                OPC_WIPE: begin
                    mode_d = MD_WIPE;
                    acnt_d = '0;
                end
                OPC_LOAD_GO, OPC_WIPE_GO: begin
                    if ((evt.val == OPC_LOAD_GO && mode_q == MD_LOAD) ||
                        (evt.val == OPC_WIPE_GO && mode_q == MD_WIPE)) begin
                        mode_d   = MD_READ;
                        acnt_d   = '0;
                        launched = 1'b1;
                        if (wp_n) begin
                            tload  = 1'b1;
                            tval   = (mode_q == MD_LOAD) ? CNT_W'(LOAD_CYC) : CNT_W'(WIPE_CYC);
                            op_d   = (mode_q == MD_LOAD) ? OP_LOAD : OP_WIPE;
                            fail_d = 1'b0;
                        end else begin
                            fail_d = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end else if (free_addr) begin
            if (mode_q == MD_IDENT) begin
                idx_d = '0;
            end else if ((mode_q == MD_READ || mode_q == MD_LOAD || mode_q == MD_WIPE) &&
                         acnt_q < addr_need(mode_q)) begin
                acnt_d = acnt_q + 2'd1;
                if (mode_q != MD_WIPE && acnt_q == 2'd0) begin
                    col_d = col_of(area_q, evt.val);
                end else begin
                    bi = (mode_q == MD_WIPE) ? int'(acnt_q) : int'(acnt_q) - 1;
                    row_d[BUS_W*bi +: BUS_W] = evt.val;
                end
                if (mode_q == MD_READ && acnt_q == addr_need(mode_q) - 2'd1) begin
                    tload    = 1'b1;
                    tval     = CNT_W'(READ_CYC);
                    op_d     = OP_READ;
                    acnt_d   = '0;
                    launched = 1'b1;
                end
            end
        end else if (free_data && mode_q == MD_LOAD && acnt_q == addr_need(MD_LOAD)) begin
            wrv_d = 1'b1;
            wrb_d = evt.val;
        end

        if (launched && area_q == AR_HIGH) begin
            area_d = AR_LOW;
        end

        if (re_rise && mode_q == MD_IDENT && idx_q != 2'd2) begin
            idx_d = idx_q + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MD_READ;
            area_q <= AR_LOW;
            op_q   <= OP_READ;
            acnt_q <= '0;
            col_q  <= '0;
            row_q  <= '0;
            fail_q <= 1'b0;
            idx_q  <= '0;
            wrv_q  <= 1'b0;
            wrb_q  <= '0;
        end else begin
            mode_q <= mode_d;
            area_q <= area_d;
            op_q   <= op_d;
            acnt_q <= acnt_d;
            col_q  <= col_d;
            row_q  <= row_d;
            fail_q <= fail_d;
            idx_q  <= idx_d;
            wrv_q  <= wrv_d;
            wrb_q  <= wrb_d;
        end
    end

    assign mode_o    = mode_q;
    assign col_o     = col_q;
    assign row_o     = row_q;
    assign fail_o    = fail_q;
    assign id_idx_o  = idx_q;
    assign wr_vld_o  = wrv_q;
    assign wr_byte_o = wrb_q;

    assert_busy_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && evt.vld && evt.kind == BK_CMD &&
         evt.val != OPC_RESET && evt.val != OPC_STATUS)
        |=> ($stable(mode_q) && $stable(area_q)));

    assert_wipe_extra_R5: assert property (@(posedge clk) disable iff (rst)
        (free_addr && mode_q == MD_WIPE && acnt_q == 2'd2) |=> $stable(row_q));

    assert_data_after_addr_R6: assert property (@(posedge clk) disable iff (rst)
        wrv_q |-> (mode_q == MD_LOAD && acnt_q == 2'd3));

    assert_wp_block_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_ok && evt.val == OPC_LOAD_GO && mode_q == MD_LOAD && !wp_n)
        |=> (fail_q && !busy));

    assert_reset_clears_R12: assert property (@(posedge clk) disable iff (rst)
        (cmd_ok && evt.val == OPC_RESET && !reset_locked)
        |=> (col_q == '0 && row_q == '0 && busy && area_q == AR_LOW));

endmodule

// File: rtl/nand_cmd_frontend.sv
module nand_cmd_frontend
    import nand_fe_pkg::*;
#(
    parameter int          READ_CYC  = 500,
    parameter int          PROG_CYC  = 4000,
    parameter int          ERASE_CYC = 40000,
    parameter int          RESET_CYC = 100,
    parameter logic [7:0]  MAKER_ID  = 8'h3C,
    parameter logic [7:0]  DEVICE_ID = 8'hA6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ce_n,
    input  logic        cle,
    input  logic        ale,
    input  logic        we_n,
    input  logic        re_n,
    input  logic        wp_n,
    input  logic [7:0]  io_in,
    output logic [7:0]  io_out,
    output logic        io_oe,
    output logic        rb,
    output logic [9:0]  col_addr,
    output logic [15:0] row_addr,
    output logic        wr_valid,
    output logic [7:0]  wr_data
);

    localparam int MAX_A   = (READ_CYC > PROG_CYC) ? READ_CYC : PROG_CYC;
    localparam int MAX_B   = (ERASE_CYC > RESET_CYC) ? ERASE_CYC : RESET_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    bus_evt_t         evt;
    logic             re_rise;
    logic             busy;
    logic             tload;
    logic [CNT_W-1:0] tval;
    mode_e            mode;
    logic             fail;
    logic [1:0]       id_idx;
    logic [7:0]       id_byte;
    logic             shows_status;

    nand_bus_sampler i_sampler (
        .clk     (clk),
        .rst     (rst),
        .ce_n    (ce_n),
        .cle     (cle),
        .ale     (ale),
        .we_n    (we_n),
        .re_n    (re_n),
        .io_in   (io_in),
        .evt     (evt),
        .re_rise (re_rise)
    );

    nand_cmd_decoder #(
        .CNT_W     (CNT_W),
        .READ_CYC  (READ_CYC),
        .LOAD_CYC  (PROG_CYC),
        .WIPE_CYC  (ERASE_CYC),
        .RESET_CYC (RESET_CYC)
    ) i_decoder (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .re_rise   (re_rise),
        .wp_n      (wp_n),
        .busy      (busy),
        .tload     (tload),
        .tval      (tval),
        .mode_o    (mode),
        .col_o     (col_addr),
        .row_o     (row_addr),
        .fail_o    (fail),
        .id_idx_o  (id_idx),
        .wr_vld_o  (wr_valid),
        .wr_byte_o (wr_data)
    );

    nand_busy_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tload),
        .load_val (tval),
        .busy     (busy)
    );

    always_comb begin
        case (id_idx)
            2'd0:    id_byte = MAKER_ID;
            2'd1:    id_byte = DEVICE_ID;
            default: id_byte = 8'h00;
        endcase
    end

    assign shows_status = (mode == MD_STATUS);
    assign io_oe  = ~ce_n & ~re_n & (shows_status | (mode == MD_IDENT));
    assign io_out = !io_oe ? 8'h00 :
                    (shows_status ? status_of(wp_n, busy, fail) : id_byte);
    assign rb     = ~busy;

    assert_status_fields_R10: assert property (@(posedge clk) disable iff (rst)
        (io_oe && shows_status)
        |-> (io_out[6] == rb && io_out[7] == wp_n && io_out[5:1] == 5'b0 && io_out[0] == fail));

    assert_oe_needs_select_R1: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> !io_oe);

endmodule

// File: tb/test_nand_cmd_frontend.sv
module test_nand_cmd_frontend;

    localparam int         T_READ  = 6;
    localparam int         T_PROG  = 40;
    localparam int         T_ERASE = 50;
    localparam int         T_RST   = 8;
    localparam logic [7:0] ID_M    = 8'h3C;
    localparam logic [7:0] ID_D    = 8'hA6;

    logic        clk;
    logic        rst;
    logic        ce_n, cle, ale, we_n, re_n, wp_n;
    logic [7:0]  io_in;
    logic [7:0]  io_out;
    logic        io_oe, rb;
    logic [9:0]  col_addr;
    logic [15:0] row_addr;
    logic        wr_valid;
    logic [7:0]  wr_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    nand_cmd_frontend #(
        .READ_CYC  (T_READ),
        .PROG_CYC  (T_PROG),
        .ERASE_CYC (T_ERASE),
        .RESET_CYC (T_RST),
        .MAKER_ID  (ID_M),
        .DEVICE_ID (ID_D)
    ) i_nand_cmd_frontend (
        .clk (clk), .rst (rst), .ce_n (ce_n), .cle (cle), .ale (ale),
        .we_n (we_n), .re_n (re_n), .wp_n (wp_n), .io_in (io_in),
        .io_out (io_out), .io_oe (io_oe), .rb (rb),
        .col_addr (col_addr), .row_addr (row_addr),
        .wr_valid (wr_valid), .wr_data (wr_data)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic c, input logic a, input logic [7:0] b);
        @(negedge clk);
        cle = c; ale = a; io_in = b; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b); put(1'b1, 1'b0, b); endtask
    task automatic adr(input logic [7:0] b); put(1'b0, 1'b1, b); endtask
    task automatic dat(input logic [7:0] b); put(1'b0, 1'b0, b); endtask

    task automatic rd(output logic [7:0] v, output logic oe);
        @(negedge clk);
        re_n = 1'b0;
        @(negedge clk);
        v = io_out; oe = io_oe;
        re_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (rb === 1'b0 && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic       oe;
        int         n;
        ce_n = 0; cle = 0; ale = 0; we_n = 1; re_n = 1; wp_n = 1; io_in = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R2: reset state
        chk("R2 rb", rb, 1);
        chk("R2 col", col_addr, 0);
        chk("R2 row", row_addr, 0);
        chk("R2 oe", io_oe, 0);
        chk("R2 wr_valid", wr_valid, 0);
        cmd(8'h70);
        rd(v, oe);
        chk("R2 status C0", v, 8'hC0);
        chk("R10 oe in status", oe, 1);

        // R1: strobes with ce_n high are ignored
        ce_n = 1;
        cmd(8'h90);
        ce_n = 0;
        rd(v, oe);
        chk("R1 deselected cmd ignored", v, 8'hC0);
        ce_n = 1;
        cmd(8'h00); adr(8'h33); adr(8'h44); adr(8'h55);
        chk("R1 deselected addr ignored", col_addr, 0);
        chk("R1 no busy when deselected", rb, 1);
        ce_n = 0;

        // R3: sweep of column byte over three pointer areas
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 256; b++) begin
                logic [9:0] ex;
                case (a)
                    0: begin cmd(8'h00); ex = 10'(b); end
                    1: begin cmd(8'h01); ex = 10'(256 + b); end
                    default: begin cmd(8'h50); ex = 10'(512 + (b % 16)); end
                endcase
                adr(8'(b)); adr(8'h11); adr(8'h22);
                busy_len(n);
                chk("R3 read busy length", n, T_READ);
                chk("R3 column", col_addr, ex);
                if (b == 0) chk("R3 row", row_addr, 16'h2211);
            end
        end

        // R4: pointer persistence
        cmd(8'h50); adr(8'h27); adr(8'h01); adr(8'h02);
        busy_len(n);
        chk("R4 spare col", col_addr, 519);
        adr(8'h05); adr(8'h01); adr(8'h02);
        busy_len(n);
        chk("R4 spare persists, read restarts", n, T_READ);
        chk("R4 spare persists col", col_addr, 517);
        cmd(8'h01); adr(8'h09); adr(8'h01); adr(8'h02);
        busy_len(n);
        chk("R4 upper col", col_addr, 265);
        adr(8'h09); adr(8'h01); adr(8'h02);
        busy_len(n);
        chk("R4 upper reverts", col_addr, 9);

        // R6 / R5: program load
        cmd(8'h00);
        cmd(8'h80);
        chk("R1 cmd no data pulse", wr_valid, 0);
        adr(8'h03);
        chk("R1 addr no data pulse", wr_valid, 0);
        adr(8'h34); adr(8'h12);
        adr(8'h77);
        chk("R5 extra addr col", col_addr, 3);
        chk("R5 extra addr row", row_addr, 16'h1234);
        chk("R5 extra addr not data", wr_valid, 0);
        dat(8'hA5);
        chk("R6 data pulse", wr_valid, 1);
        chk("R6 data byte", wr_data, 8'hA5);
        dat(8'h5A);
        chk("R6 data byte 2", wr_data, 8'h5A);
        dat(8'h00);
        chk("R6 data pulse 3", wr_valid, 1);
        cmd(8'h10);
        busy_len(n);
        chk("R6 program busy length", n, T_PROG);
        cmd(8'h70);
        rd(v, oe);
        chk("R10 status after program", v, 8'hC0);

        // R7: confirm without setup
        cmd(8'h00);
        cmd(8'h10);
        chk("R7 lone 10h no busy", rb, 1);
        cmd(8'hD0);
        chk("R7 lone D0h no busy", rb, 1);

        // R8 / R5: erase
        cmd(8'h60); adr(8'h44); adr(8'h03); adr(8'h99);
        chk("R5 erase row", row_addr, 16'h0344);
        cmd(8'hD0);
        busy_len(n);
        chk("R8 erase busy length", n, T_ERASE);

        // R9 / R10: filtering while busy
        cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h00);
        cmd(8'h10);
        cmd(8'h70);
        rd(v, oe);
        chk("R10 status while busy", v, 8'h80);
        cmd(8'h90);
        rd(v, oe);
        chk("R9 ident ignored while busy", v, 8'h80);
        cmd(8'h50);
        adr(8'h0F);
        busy_len(n);
        chk("R9 addr ignored while busy", col_addr, 0);
        rd(v, oe);
        chk("R10 status mode holds", v, 8'hC0);
        cmd(8'h80); adr(8'h21); adr(8'h00); adr(8'h00);
        chk("R9 pointer cmd ignored while busy", col_addr, 10'h021);

        // R11: write protect
        wp_n = 0;
        cmd(8'h10);
        chk("R11 program blocked", rb, 1);
        cmd(8'h70);
        rd(v, oe);
        chk("R11 status fail protected", v, 8'h41);
        cmd(8'h60); adr(8'h01); adr(8'h02);
        cmd(8'hD0);
        chk("R11 erase blocked", rb, 1);
        wp_n = 1;
        cmd(8'h60); adr(8'h01); adr(8'h02);
        cmd(8'hD0);
        busy_len(n);
        chk("R11 erase after protect", n, T_ERASE);
        cmd(8'h70);
        rd(v, oe);
        chk("R11 fail cleared", v, 8'hC0);

        // R12: reset
        cmd(8'h50); adr(8'h2A); adr(8'h55); adr(8'h66);
        busy_len(n);
        chk("R12 pre col", col_addr, 522);
        cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03);
        cmd(8'h10);
        cmd(8'hFF);
        busy_len(n);
        chk("R12 reset aborts program", n, T_RST);
        chk("R12 col cleared", col_addr, 0);
        chk("R12 row cleared", row_addr, 0);
        cmd(8'h70);
        rd(v, oe);
        chk("R12 status after reset", v, 8'hC0);
        cmd(8'h80); adr(8'h07); adr(8'h00); adr(8'h00);
        chk("R12 pointer to lower", col_addr, 7);
        cmd(8'hFF);
        cmd(8'hFF);
        busy_len(n);
        chk("R12 second reset ignored", n, T_RST - 4);

        // R13: identification
        cmd(8'h90); adr(8'h00);
        rd(v, oe);
        chk("R13 maker", v, ID_M);
        chk("R13 oe", oe, 1);
        rd(v, oe);
        chk("R13 device", v, ID_D);
        rd(v, oe);
        chk("R13 after device", v, 8'h00);
        rd(v, oe);
        chk("R13 stays zero", v, 8'h00);
        chk("R13 oe off with re high", io_oe, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule